// File: doc/BRIEF.md
# Word ALU with Zero and Negative Flags

This block is the integer execution unit of a word-oriented processor in which every register and memory word is 32 bits wide. Each cycle it receives an operation code, the current contents of the instruction's main register and the already resolved operand value. Combinationally it returns the new value for the main register together with a write-enable. It also keeps two registered condition flags, zero (Z) and negative (N), which the sequencer reads for conditional jumps.

The unit covers addition and subtraction in both directions, increment, decrement and negation, and the bitwise operations including the forms with a complemented operand. It also covers logical and arithmetic shifts that report on the bits pushed out, rotates, signed and unsigned compares, single-bit test, set and clear, and a search for the highest set bit or the highest clear bit. Compares and bit tests only touch the flags and never request a register write. Every operation that is not defined to change a flag leaves it exactly as it was.

Top module: `word_alu`

## Requirements
- R1: Opcodes are 5 bits: ADD=0, SUB=1, RSUB=2, INC=3, DEC=4, NEG=5, AND=6, OR=7, XOR=8, NOT=9, ANDN=10, ORN=11, SHL=12, SHR=13, ASR=14, ROTL=15, ROTR=16, COMP=17, UCOMP=18, COMPZ=19, TBIT=20, SBIT=21, CBIT=22, FFO=23, FLZ=24. `wr_en_o` is 1 for every defined opcode except COMP, UCOMP, COMPZ and TBIT; codes 25 to 31 give `wr_en_o`=0, `result_o`=0 and leave both flags unchanged.
- R2: Arithmetic modulo 2^32: ADD gives reg+value, SUB reg-value, RSUB value-reg, INC value+1, DEC value-1, NEG 0-value.
- R3: Logic: AND, OR, XOR combine reg and value bitwise; NOT gives ~value; ANDN gives reg & ~value; ORN gives reg | ~value.
- R4: SHL shifts reg left, filling zeros at bit 0, and sets Z to 1 exactly when the bits shifted out of the top were all 0; N is unchanged.
- R5: SHR shifts reg right with zero fill and ASR shifts right copying bit 31; both set Z to 1 exactly when the bits shifted out of the bottom were all 0; N is unchanged.
- R6: ROTL and ROTR rotate reg left or right, reinserting lost bits at the opposite end, and change neither flag.
- R7: Shift, rotate and bit-select amounts are taken from value[4:0] only; an amount of 0 returns reg unchanged and a shift by 0 sets Z to 1.
- R8: COMP sets Z = (reg == value) and N = (reg < value) as signed numbers; UCOMP does the same with an unsigned less-than.
- R9: COMPZ sets Z = (value == 0) and N = value[31].
- R10: TBIT copies bit value[4:0] of reg into Z (N unchanged); SBIT returns reg with that bit set and CBIT returns it with that bit cleared, both without changing flags.
- R11: FFO returns the position of the most significant 1 in value (number of bits to its right); for value 0 it returns all ones (-1) and sets Z and N to 1; otherwise flags are unchanged.
- R12: FLZ returns the position of the most significant 0 in value; for value all ones it returns -1 and sets Z and N to 1; otherwise flags are unchanged.
- R13: Flags update on the rising clock edge only when `valid_i` is 1; with `valid_i` 0 they hold; an active-low reset clears both to 0; arithmetic, logic, rotate, SBIT and CBIT operations leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, flags update on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the flags |
| valid_i | input | 1 | Operation is executed this cycle (flag update enable) |
| op_i | input | 5 | Operation code, encoding in R1 |
| reg_i | input | WIDTH | Current main register value |
| opnd_i | input | WIDTH | Resolved operand value |
| result_o | output | WIDTH | New main register value (combinational) |
| wr_en_o | output | 1 | Main register write request |
| flag_z_o | output | 1 | Registered zero flag |
| flag_n_o | output | 1 | Registered negative flag |

## Verification
The bench builds the unit with its default WIDTH of 32, so the shift amount field is five bits wide and every amount from 0 to 31 is swept for all five shift and rotate kinds, including the zero amount where Z must report an empty set of lost bits. The full 32-bit width brings the signed and unsigned compare boundaries (0x7FFFFFFF against 0x80000000) and the all-zeros and all-ones scan inputs within reach, and the undefined codes 25 to 31 exist because the opcode field stays 5 bits. Directed corner cases are followed by a long run of random opcodes and data, each checked against a behavioural model that tracks the flags across operations.

// File: rtl/word_alu_pkg.sv
package word_alu_pkg;

    typedef enum logic [4:0] {
        OP_ADD   = 5'd0,
        OP_SUB   = 5'd1,
        OP_RSUB  = 5'd2,
        OP_INC   = 5'd3,
        OP_DEC   = 5'd4,
        OP_NEG   = 5'd5,
        OP_AND   = 5'd6,
        OP_OR    = 5'd7,
        OP_XOR   = 5'd8,
        OP_NOT   = 5'd9,
        OP_ANDN  = 5'd10,
        OP_ORN   = 5'd11,
        OP_SHL   = 5'd12,
        OP_SHR   = 5'd13,
        OP_ASR   = 5'd14,
        OP_ROTL  = 5'd15,
        OP_ROTR  = 5'd16,
        OP_COMP  = 5'd17,
        OP_UCOMP = 5'd18,
        OP_COMPZ = 5'd19,
        OP_TBIT  = 5'd20,
        OP_SBIT  = 5'd21,
        OP_CBIT  = 5'd22,
        OP_FFO   = 5'd23,
        OP_FLZ   = 5'd24
    } alu_op_e;

    typedef enum logic [2:0] {
        SH_LEFT_LOG  = 3'd0,
        SH_RIGHT_LOG = 3'd1,
        SH_RIGHT_AR  = 3'd2,
        SH_ROT_LEFT  = 3'd3,
        SH_ROT_RIGHT = 3'd4
    } shift_kind_e;

    typedef struct packed {
        logic z;
        logic n;
    } alu_flags_t;

endpackage

// File: rtl/word_alu_shift.sv
module word_alu_shift
    import word_alu_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int SHW  = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] data_i,
    input  logic [SHW-1:0]   amt_i,
    input  shift_kind_e      kind_i,
    output logic [WIDTH-1:0] res_o,
    output logic             lost_zero_o
);

    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    logic [SHW:0]       back_amt;
    logic [2*WIDTH-1:0] sext;
    logic [2*WIDTH-1:0] sext_sh;
    logic [WIDTH-1:0]   hi_lost;
    logic [WIDTH-1:0]   lo_lost;

    always_comb begin
        back_amt = (SHW+1)'(WIDTH) - {1'b0, amt_i};
        sext     = {{WIDTH{data_i[WIDTH-1]}}, data_i};
        sext_sh  = sext >> amt_i;
        // bits that leave the word at the top or the bottom
        hi_lost  = data_i & ~(ALL_ONES >> amt_i);
        lo_lost  = data_i & ~(ALL_ONES << amt_i);

        res_o       = data_i << amt_i;
        lost_zero_o = (hi_lost == '0);
        case (kind_i)
            SH_LEFT_LOG: begin
                res_o       = data_i << amt_i;
                lost_zero_o = (hi_lost == '0);
            end
            SH_RIGHT_LOG: begin
                res_o       = data_i >> amt_i;
                lost_zero_o = (lo_lost == '0);
            end
            SH_RIGHT_AR: begin
                res_o       = sext_sh[WIDTH-1:0];
                lost_zero_o = (lo_lost == '0);
            end
            SH_ROT_LEFT: begin
                res_o       = (data_i << amt_i) | (data_i >> back_amt);
                lost_zero_o = 1'b1;
            end
            SH_ROT_RIGHT: begin
                res_o       = (data_i >> amt_i) | (data_i << back_amt);
                lost_zero_o = 1'b1;
            end
            default: begin
                res_o       = data_i;
                lost_zero_o = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/word_alu_scan.sv
module word_alu_scan #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] data_i,
    input  logic             seek_zero_i,
    output logic [WIDTH-1:0] index_o,
    output logic             none_o
);

    logic [WIDTH-1:0] probe;

    always_comb begin
        probe   = seek_zero_i ? ~data_i : data_i;
        index_o = '1;
        none_o  = 1'b1;
        // later (higher) hits override earlier ones
        for (int i = 0; i < WIDTH; i++) begin
            if (probe[i]) begin
                index_o = WIDTH'(i);
                none_o  = 1'b0;
            end
        end
    end

endmodule

// File: rtl/word_alu_cmp.sv
module word_alu_cmp #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             signed_i,
    output logic             eq_o,
    output logic             lt_o
);

    logic [WIDTH:0] a_ext;
    logic [WIDTH:0] b_ext;
    logic [WIDTH:0] diff;

    always_comb begin
        a_ext = {signed_i & a_i[WIDTH-1], a_i};
        b_ext = {signed_i & b_i[WIDTH-1], b_i};
        diff  = a_ext - b_ext;
        eq_o  = (a_i == b_i);
        lt_o  = diff[WIDTH];
    end

endmodule

// File: rtl/word_alu.sv
module word_alu
    import word_alu_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int SHW  = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic [4:0]       op_i,
    input  logic [WIDTH-1:0] reg_i,
    input  logic [WIDTH-1:0] opnd_i,
    output logic [WIDTH-1:0] result_o,
    output logic             wr_en_o,
    output logic             flag_z_o,
    output logic             flag_n_o
);

    alu_op_e          op;
    logic [SHW-1:0]   amt;
    logic [WIDTH-1:0] bit_sel;

    // shared adder
    logic [WIDTH-1:0] add_a;
    logic [WIDTH-1:0] add_b;
    logic             add_cin;
    logic [WIDTH-1:0] add_sum;

    // shifter
    shift_kind_e      sh_kind;
    logic [WIDTH-1:0] sh_res;
    logic             sh_lost_zero;

    // compare
    logic [WIDTH-1:0] cmp_a;
    logic [WIDTH-1:0] cmp_b;
    logic             cmp_signed;
    logic             cmp_eq;
    logic             cmp_lt;

    // scan
    logic [WIDTH-1:0] sc_index;
    logic             sc_none;

    alu_flags_t flags_d;
    alu_flags_t flags_q;
    alu_flags_t flags_calc;
    logic [WIDTH-1:0] res_calc;
    logic             wr_calc;

    assign op      = alu_op_e'(op_i);
    assign amt     = opnd_i[SHW-1:0];
    assign bit_sel = {{(WIDTH-1){1'b0}}, 1'b1} << amt;

    // operand steering for the single adder
    always_comb begin
        add_a   = reg_i;
        add_b   = opnd_i;
        add_cin = 1'b0;
        case (op)
            OP_SUB: begin
                add_a   = reg_i;
                add_b   = ~opnd_i;
                add_cin = 1'b1;
            end
            OP_RSUB: begin
                add_a   = opnd_i;
                add_b   = ~reg_i;
                add_cin = 1'b1;
            end
            OP_INC: begin
                add_a   = opnd_i;
                add_b   = '0;
                add_cin = 1'b1;
            end
            OP_DEC: begin
                add_a   = opnd_i;
                add_b   = '1;
                add_cin = 1'b0;
            end
            OP_NEG: begin
                add_a   = '0;
                add_b   = ~opnd_i;
                add_cin = 1'b1;
            end
            default: begin
                add_a   = reg_i;
                add_b   = opnd_i;
                add_cin = 1'b0;
            end
        endcase
        add_sum = add_a + add_b + {{(WIDTH-1){1'b0}}, add_cin};
    end

    always_comb begin
        case (op)
            OP_SHR:  sh_kind = SH_RIGHT_LOG;
            OP_ASR:  sh_kind = SH_RIGHT_AR;
            OP_ROTL: sh_kind = SH_ROT_LEFT;
            OP_ROTR: sh_kind = SH_ROT_RIGHT;
            default: sh_kind = SH_LEFT_LOG;
        endcase
    end

    word_alu_shift #(.WIDTH(WIDTH)) shift_i (
        .data_i      (reg_i),
        .amt_i       (amt),
        .kind_i      (sh_kind),
        .res_o       (sh_res),
        .lost_zero_o (sh_lost_zero)
    );

    // COMPZ reuses the signed compare against zero
    assign cmp_a      = (op == OP_COMPZ) ? opnd_i : reg_i;
    assign cmp_b      = (op == OP_COMPZ) ? '0 : opnd_i;
    assign cmp_signed = (op != OP_UCOMP);

    word_alu_cmp #(.WIDTH(WIDTH)) cmp_i (
        .a_i      (cmp_a),
        .b_i      (cmp_b),
        .signed_i (cmp_signed),
        .eq_o     (cmp_eq),
        .lt_o     (cmp_lt)
    );

    word_alu_scan #(.WIDTH(WIDTH)) scan_i (
        .data_i      (opnd_i),
        .seek_zero_i (op == OP_FLZ),
        .index_o     (sc_index),
        .none_o      (sc_none)
    );

    // next-value process
    always_comb begin
        res_calc   = '0;
        wr_calc    = 1'b0;
        flags_calc = flags_q;
        case (op)
            OP_ADD, OP_SUB, OP_RSUB, OP_INC, OP_DEC, OP_NEG: begin
                res_calc = add_sum;
                wr_calc  = 1'b1;
            end
            OP_AND: begin
                res_calc = reg_i & opnd_i;
                wr_calc  = 1'b1;
            end
            OP_OR: begin
                res_calc = reg_i | opnd_i;
                wr_calc  = 1'b1;
            end
            OP_XOR: begin
                res_calc = reg_i ^ opnd_i;
                wr_calc  = 1'b1;
            end
            OP_NOT: begin
                res_calc = ~opnd_i;
                wr_calc  = 1'b1;
            end
            OP_ANDN: begin
                res_calc = reg_i & ~opnd_i;
                wr_calc  = 1'b1;
            end
            OP_ORN: begin
                res_calc = reg_i | ~opnd_i;
                wr_calc  = 1'b1;
            end
            OP_SHL, OP_SHR, OP_ASR: begin
                res_calc     = sh_res;
                wr_calc      = 1'b1;
                flags_calc.z = sh_lost_zero;
            end
            OP_ROTL, OP_ROTR: begin
                res_calc = sh_res;
                wr_calc  = 1'b1;
            end
            OP_COMP, OP_UCOMP, OP_COMPZ: begin
                flags_calc.z = cmp_eq;
                flags_calc.n = cmp_lt;
            end
            OP_TBIT: begin
                flags_calc.z = reg_i[amt];
            end
            OP_SBIT: begin
                res_calc = reg_i | bit_sel;
                wr_calc  = 1'b1;
            end
            OP_CBIT: begin
                res_calc = reg_i & ~bit_sel;
                wr_calc  = 1'b1;
            end
            OP_FFO, OP_FLZ: begin
                res_calc = sc_index;
                wr_calc  = 1'b1;
                if (sc_none) begin
                    flags_calc.z = 1'b1;
                    flags_calc.n = 1'b1;
                end
            end
            default: begin
                res_calc   = '0;
                wr_calc    = 1'b0;
                flags_calc = flags_q;
            end
        endcase

        flags_d = valid_i ? flags_calc : flags_q;
    end

    // register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign result_o = res_calc;
    assign wr_en_o  = wr_calc;
    assign flag_z_o = flags_q.z;
    assign flag_n_o = flags_q.n;

endmodule

// File: rtl/word_alu_chk.sv
module word_alu_chk
    import word_alu_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int SHW  = $clog2(WIDTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             valid_i,
    input logic [4:0]       op_i,
    input logic [WIDTH-1:0] reg_i,
    input logic [WIDTH-1:0] opnd_i,
    input logic [WIDTH-1:0] result_o,
    input logic             wr_en_o,
    input logic             flag_z_o,
    input logic             flag_n_o
);

    p_cmp_nowrite_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_COMP || op_i == OP_UCOMP || op_i == OP_COMPZ || op_i == OP_TBIT)
        |-> !wr_en_o);

    p_undef_nowrite_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i > 5'd24) |-> (!wr_en_o && result_o == '0));

    p_idle_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable({flag_z_o, flag_n_o}));

    p_rot_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && (op_i == OP_ROTL || op_i == OP_ROTR))
        |=> $stable({flag_z_o, flag_n_o}));

    p_comp_eq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == OP_COMP)
        |=> (flag_z_o == ($past(reg_i) == $past(opnd_i))));

    p_compz_sign_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == OP_COMPZ) |=> (flag_n_o == $past(opnd_i[WIDTH-1])));

    p_shift_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_i == OP_SHL || op_i == OP_SHR || op_i == OP_ASR) && opnd_i[SHW-1:0] == '0)
        |-> (result_o == reg_i));

    p_ffo_none_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_FFO && opnd_i == '0) |-> (&result_o));

    p_ffo_hit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_FFO && opnd_i != '0)
        |-> (result_o < WIDTH && opnd_i[result_o[SHW-1:0]]));

    p_flz_hit_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_FLZ && opnd_i != '1)
        |-> (result_o < WIDTH && !opnd_i[result_o[SHW-1:0]]));

endmodule

bind word_alu word_alu_chk #(.WIDTH(WIDTH)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid_i  (valid_i),
    .op_i     (op_i),
    .reg_i    (reg_i),
    .opnd_i   (opnd_i),
    .result_o (result_o),
    .wr_en_o  (wr_en_o),
    .flag_z_o (flag_z_o),
    .flag_n_o (flag_n_o)
);

// File: tb/word_alu_tb_top.sv
`timescale 1ns/1ps
module word_alu_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [4:0]  op_i = '0;
    logic [31:0] reg_i = '0;
    logic [31:0] opnd_i = '0;
    logic [31:0] result_o;
    logic        wr_en_o;
    logic        flag_z_o;
    logic        flag_n_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic mz = 1'b0;
    logic mn = 1'b0;

    always #2.5 clk = ~clk;

    word_alu #(.WIDTH(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
        .reg_i(reg_i), .opnd_i(opnd_i), .result_o(result_o),
        .wr_en_o(wr_en_o), .flag_z_o(flag_z_o), .flag_n_o(flag_n_o)
    );

    function automatic string tag(input int op);
        if (op <= 5)  return "R2";
        if (op <= 11) return "R3";
        if (op == 12) return "R4";
        if (op <= 14) return "R5";
        if (op <= 16) return "R6";
        if (op <= 18) return "R8";
        if (op == 19) return "R9";
        if (op <= 22) return "R10";
        if (op == 23) return "R11";
        if (op == 24) return "R12";
        return "R1";
    endfunction

    // behavioural reference
    function automatic void model(input int op, input logic [31:0] r, input logic [31:0] v,
                                  input logic zi, input logic ni,
                                  output logic [31:0] res, output logic wr,
                                  output logic zo, output logic no);
        int sh;
        sh  = int'(v[4:0]);
        res = '0; wr = 1'b1; zo = zi; no = ni;
        case (op)
            0: res = r + v;
            1: res = r - v;
            2: res = v - r;
            3: res = v + 1;
            4: res = v - 1;
            5: res = 32'd0 - v;
            6: res = r & v;
            7: res = r | v;
            8: res = r ^ v;
            9: res = ~v;
            10: res = r & ~v;
            11: res = r | ~v;
            12: begin
                res = r << sh; zo = 1'b1;
                for (int i = 32 - sh; i < 32; i++) if (r[i]) zo = 1'b0;
            end
            13, 14: begin
                res = r >> sh; zo = 1'b1;
                if (op == 14) for (int i = 32 - sh; i < 32; i++) res[i] = r[31];
                for (int i = 0; i < sh; i++) if (r[i]) zo = 1'b0;
            end
            15: for (int i = 0; i < 32; i++) res[(i + sh) % 32] = r[i];
            16: for (int i = 0; i < 32; i++) res[i] = r[(i + sh) % 32];
            17: begin wr = 1'b0; zo = (r == v); no = ($signed(r) < $signed(v)); end
            18: begin wr = 1'b0; zo = (r == v); no = (r < v); end
            19: begin wr = 1'b0; zo = (v == 0); no = v[31]; end
            20: begin wr = 1'b0; zo = r[sh]; end
            21: begin res = r; res[sh] = 1'b1; end
            22: begin res = r; res[sh] = 1'b0; end
            23, 24: begin
                res = 32'hFFFF_FFFF;
                for (int i = 0; i < 32; i++) if (v[i] == (op == 23)) res = 32'(i);
                if (res == 32'hFFFF_FFFF) begin zo = 1'b1; no = 1'b1; end
            end
            default: wr = 1'b0;
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input int op, input logic [31:0] r, input logic [31:0] v,
                          input bit vld = 1'b1);
        logic [31:0] er;
        logic ew, ez, en;
        @(negedge clk);
        op_i = 5'(op); reg_i = r; opnd_i = v; valid_i = vld;
        model(op, r, v, mz, mn, er, ew, ez, en);
        #1;
        if (op <= 24) check(tag(op), "result", result_o, er);
        else          check("R1", "result", result_o, 32'd0);
        check((op <= 24) ? "R1" : "R1", "wr_en", {31'd0, wr_en_o}, {31'd0, ew});
        @(posedge clk);
        #1;
        if (vld) begin mz = ez; mn = en; end
        check(vld ? tag(op) : "R13", "flags", {30'd0, flag_z_o, flag_n_o}, {30'd0, mz, mn});
        valid_i = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R13: reset clears the flags
        check("R13", "reset flags", {30'd0, flag_z_o, flag_n_o}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 arithmetic
        run_op(0, 32'hFFFF_FFFF, 32'd2);
        run_op(1, 32'd5, 32'd9);
        run_op(2, 32'd5, 32'd9);
        run_op(3, 32'd0, 32'hFFFF_FFFF);
        run_op(4, 32'd7, 32'd0);
        run_op(5, 32'd0, 32'd43);
        // R3 logic
        run_op(6, 32'hF0F0_1234, 32'h0FF0_FFFF);
        run_op(7, 32'hF000_0000, 32'h0000_000F);
        run_op(8, 32'hAAAA_5555, 32'hFFFF_0000);
        run_op(9, 32'd0, 32'h1234_5678);
        run_op(10, 32'hFFFF_FFFF, 32'h00FF_00FF);
        run_op(11, 32'h0, 32'hFFFF_0000);

        // R8 set flags to a known non-zero state, then undefined codes (R1)
        run_op(17, 32'h8000_0000, 32'h7FFF_FFFF);
        for (int c = 25; c < 32; c++) run_op(c, 32'h1234, 32'h0);
        // R13 idle: a compare with valid low must not change flags
        run_op(17, 32'd3, 32'd3, 1'b0);
        run_op(0, 32'd1, 32'd1);   // R13 add keeps flags

        // R4 R5 R6 R7 sweep of amounts
        for (int k = 12; k <= 16; k++) begin
            for (int s = 0; s < 32; s++) begin
                run_op(k, 32'h8000_0001, 32'(s));
                run_op(k, 32'h0F00_F0F0, 32'hFFFF_FFE0 | 32'(s));
            end
        end
        run_op(13, 32'h0000_0100, 32'd8);  // R5 lost bits zero
        run_op(14, 32'h8000_0100, 32'd9);  // R5 lost bit one

        // R8 compares at boundaries
        run_op(17, 32'h7FFF_FFFF, 32'h8000_0000);
        run_op(18, 32'h7FFF_FFFF, 32'h8000_0000);
        run_op(18, 32'h8000_0000, 32'h8000_0000);
        // R9
        run_op(19, 32'h0, 32'h0);
        run_op(19, 32'h0, 32'h8000_0000);
        run_op(19, 32'h0, 32'h1);
        // R10
        run_op(20, 32'h0000_0400, 32'd10);
        run_op(20, 32'h0000_0400, 32'd11);
        run_op(21, 32'h0, 32'd31);
        run_op(22, 32'hFFFF_FFFF, 32'd0);
        run_op(20, 32'h8000_0000, 32'h0000_005F);  // R7 upper bits of amount ignored
        // R11
        run_op(19, 32'h0, 32'h1);  // clear flags first
        run_op(23, 32'h0, 32'h1);
        run_op(23, 32'h0, 32'h8000_0000);
        run_op(23, 32'h0, 32'h0000_0F00);
        run_op(23, 32'h0, 32'h0);
        // R12
        run_op(19, 32'h0, 32'h1);
        run_op(24, 32'h0, 32'h7FFF_FFFF);
        run_op(24, 32'h0, 32'hFFFF_FFFE);
        run_op(24, 32'h0, 32'h0);
        run_op(24, 32'h0, 32'hFFFF_FFFF);

        // random mix over all codes
        for (int n = 0; n < 3000; n++) begin
            int oc;
            logic [31:0] rv, vv;
            oc = int'($urandom_range(0, 31));
            rv = $urandom();
            vv = $urandom();
            if (n % 7 == 0) vv = '0;
            if (n % 11 == 0) vv = '1;
            run_op(oc, rv, vv, ($urandom_range(0, 9) != 0));
        end

        done = 1'b1;
        finish_run();
    end

endmodule